// File: doc/BRIEF.md
# Voltage Code Qualifier with Transition Blanking

This block sits between the eight voltage-select lines driven by a processor and the reference converter of a multiphase supply. The lines are asynchronous and their bits do not switch at the same instant, so the block passes them through a synchronizer and watches for any difference between consecutive sampled values. A new code goes to the converter only after it has held steady for a programmable number of clock ticks. Until then the previously accepted code is held frozen.

Each detected change also starts a longer blanking window, and every later change restarts it. The window tells the supervisory comparators to suppress power-good and overvoltage reporting while the output voltage is moving. Code steps may go up or down and may come as a run of small increments.

One code value is reserved to mean "processor requests the supply off". While that value is present, power-good is held low at once. A shutdown request is raised only after the value has persisted for a programmable time. All times are given in clock cycles as parameters.

Top module: `vid_qualifier`

## Requirements
- R1: After reset, `code_o` is 0 and `vld_o`, `blank_o`, `off_req_o` and `pg_hold_o` are all low.
- R2: A change on `code_i` is detected at the third rising edge after it is applied: two synchronizer stages plus one compare stage. `code_o` keeps its old value and takes the new code at the edge SKEW_CYC cycles after detection, provided no further change was detected in between.
- R3: `vld_o` is high for exactly one cycle, in the cycle in which `code_o` has just been loaded. A rising `en_i` starts the same qualification and produces one such pulse for the code present at that time.
- R4: `blank_o` goes high at the edge where a change is detected and stays high for BLANK_CYC cycles. Every further detected change restarts the full window.
- R5: Changes spaced closer than SKEW_CYC cycles never reach `code_o`. Only the code that finally stays steady is loaded.
- R6: `pg_hold_o` is high whenever `en_i` is high and the synchronized code equals OFF_CODE, whose default is all ones (8'hFF). It rises two edges after the code is applied.
- R7: `off_req_o` rises once the synchronized code has equalled OFF_CODE for OFF_CYC consecutive enabled cycles. A shorter run of OFF_CODE never raises it. It falls at the first edge after the synchronized code leaves OFF_CODE.
- R8: While `en_i` is low, the next edge clears `blank_o` and `off_req_o`. Code changes during this time produce no `vld_o` and leave `code_o` unchanged. When `en_i` rises again, the skew qualification starts but no blanking window does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| code_i | input | CODE_W | Raw voltage-select code from the processor |
| code_o | output | CODE_W | Qualified code for the reference converter |
| vld_o | output | 1 | One-cycle strobe when `code_o` is loaded |
| blank_o | output | 1 | Masks power-good and overvoltage reporting |
| off_req_o | output | 1 | Shutdown request after a persistent off code |
| pg_hold_o | output | 1 | Forces power-good low while the off code is present |

## Verification
Counting from the clock edge after a new code is applied, the results fall due as follows:
- `pg_hold_o` at edge 2.
- `blank_o` rises at edge 3 and falls at edge 3+BLANK_CYC.
- `code_o` and the `vld_o` pulse at edge 3+SKEW_CYC.
- `off_req_o` at edge 2+OFF_CYC.

The bench drives inputs on falling edges and, on every falling edge for twenty cycles after each stimulus, compares all outputs against values computed from that cycle index. A missing or extra register anywhere in the path therefore shows up as a one-cycle mismatch. Bursts of changes, the enable edge and a run of the off code one cycle too short use the same cycle-indexed expectations, with the index counted from the last change.

// File: rtl/vid_pkg.sv
package vid_pkg;
  // width of a counter that must reach n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/vid_sync.sv
module vid_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vid_timer.sv
module vid_timer #(
  parameter int unsigned LOAD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int unsigned CW = vid_pkg::cnt_w(LOAD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(LOAD);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o   = (cnt_q != '0);
  // last tick of an uninterrupted run
  assign expire_o = !clr_i && !start_i && (cnt_q == CW'(1));

  a_r4_restart_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> busy_o);
  a_r8_clear_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);
endmodule

// File: rtl/vid_qualifier.sv
module vid_qualifier #(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned SKEW_CYC  = 40,
  parameter int unsigned BLANK_CYC = 25000,
  parameter int unsigned OFF_CYC   = 500,
  parameter logic [CODE_W-1:0] OFF_CODE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              vld_o,
  output logic              blank_o,
  output logic              off_req_o,
  output logic              pg_hold_o
);
  localparam int unsigned OW = vid_pkg::cnt_w(OFF_CYC);

  logic [CODE_W-1:0] sync_code, prev_q, code_q;
  logic              en_q, vld_q, chg, en_rise, skew_exp, off_match;
  logic [OW-1:0]     off_cnt_q;

  vid_sync #(.W(CODE_W), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(code_i), .q_o(sync_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= sync_code;
      en_q   <= en_i;
    end
  end

  assign chg     = en_i && (sync_code != prev_q);
  assign en_rise = en_i && !en_q;

  vid_timer #(.LOAD(SKEW_CYC)) u_skew (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!en_i), .start_i(chg || en_rise),
    .busy_o(), .expire_o(skew_exp)
  );

  vid_timer #(.LOAD(BLANK_CYC)) u_blank (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!en_i), .start_i(chg),
    .busy_o(blank_o), .expire_o()
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= skew_exp;
      if (skew_exp) code_q <= sync_code;
    end
  end

  assign off_match = en_i && (sync_code == OFF_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       off_cnt_q <= '0;
    else if (!off_match)               off_cnt_q <= '0;
    else if (off_cnt_q != OW'(OFF_CYC)) off_cnt_q <= off_cnt_q + 1'b1;
  end

  assign code_o    = code_q;
  assign vld_o     = vld_q;
  assign off_req_o = (off_cnt_q == OW'(OFF_CYC));
  assign pg_hold_o = off_match;

  a_r2_code_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(code_o));
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  a_r4_blank_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> blank_o);
  a_r7_off_needs_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_req_o |-> $past(off_match));
  a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!blank_o && !off_req_o && !vld_o));
endmodule

// File: tb/sim_vid_qualifier.sv
module sim_vid_qualifier;
  localparam int unsigned S = 4, B = 12, N = 8;
  localparam logic [7:0] OFF = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0] code_in = 8'h00;
  logic [7:0] code_out;
  logic vld, blank, off_req, pg_hold;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vid_qualifier #(.CODE_W(8), .SKEW_CYC(S), .BLANK_CYC(B), .OFF_CYC(N), .OFF_CODE(OFF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .code_i(code_in),
    .code_o(code_out), .vld_o(vld), .blank_o(blank), .off_req_o(off_req), .pg_hold_o(pg_hold)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply v at a falling edge; check every output for 20 cycles, c = edges since drive
  task automatic run_step(input logic [7:0] v, input logic [7:0] old, input bit pre_blank);
    code_in = v;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      check("R2 code", code_out, (c >= 3 + S) ? v : old);
      check("R3 vld", vld, (c == 3 + S) ? 1 : 0);
      check("R4 blank", blank, ((c >= 3 && c < 3 + B) || (pre_blank && c < 3)) ? 1 : 0);
      check("R6 pg_hold", pg_hold, (((c >= 2) ? v : old) == OFF) ? 1 : 0);
      check("R7 off_req", off_req, ((old == OFF && c < 3) || (v == OFF && c >= 2 + N)) ? 1 : 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 code", code_out, 0);
    check("R1 vld", vld, 0);
    check("R1 blank", blank, 0);
    check("R1 off_req", off_req, 0);
    check("R1 pg_hold", pg_hold, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R8: enable rise qualifies current code, no blanking
    en = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      check("R3 en vld", vld, (c == 1 + S) ? 1 : 0);
      check("R8 en no blank", blank, 0);
      check("R3 en code", code_out, 0);
    end

    // R2 R4 R6 R7: sweep every code, rising steps, then a falling step off the off code
    for (int v = 1; v < 256; v++) run_step(8'(v), 8'(v - 1), 1'b0);
    run_step(8'h3C, OFF, 1'b0);

    // R5 R4: burst of small steps spaced 3 cycles, then a final one
    code_in = 8'h3D;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      check("R5 burst code", code_out, 8'h3C);
      check("R5 burst vld", vld, 0);
      check("R4 burst blank", blank, (c >= 3) ? 1 : 0);
    end
    code_in = 8'h3B;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      check("R5 burst code", code_out, 8'h3C);
      check("R5 burst vld", vld, 0);
      check("R4 burst blank", blank, 1);
    end
    run_step(8'h3A, 8'h3C, 1'b1);

    // R8: disable mid-window, changes ignored while disabled
    code_in = 8'h55;
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R8 blank cleared", blank, 0);
    code_in = OFF;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      check("R8 code held", code_out, 8'h3A);
      check("R8 no vld", vld, 0);
      check("R8 no blank", blank, 0);
      check("R8 no off_req", off_req, 0);
      check("R8 no pg_hold", pg_hold, 0);
    end
    en = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      check("R8 reenable blank", blank, 0);
      check("R6 reenable pg_hold", pg_hold, 1);
      check("R3 reenable vld", vld, (c == 1 + S) ? 1 : 0);
      check("R7 reenable off_req", off_req, (c >= N) ? 1 : 0);
    end
    check("R3 reenable code", code_out, OFF);

    // R7: leave the off code, then a run one cycle short of the persistence time
    run_step(8'h20, OFF, 1'b0);
    code_in = OFF;
    repeat (N - 1) @(negedge clk);
    code_in = 8'h20;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      check("R7 short run", off_req, 0);
    end
    check("R7 settled code", code_out, 8'h20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule